// File: doc/BRIEF.md
# Line BIP-24 Parity Error Monitor

The block watches the line layer of a 3-column-interleaved SONET/SDH frame after descrambling. It builds a 24-bit bit-interleaved parity over every byte of a frame except the section overhead. In the following frame it compares that parity with the three received B2 bytes. The number of mismatching bits is a value from 0 to 24. It is added to a saturating bit-error counter. Any frame with a nonzero mismatch also adds one to a saturating block-error counter.

A performance-monitoring tick closes an accumulation interval. At the tick, each counter is compared with its own signal-fail and signal-degrade thresholds, and the counter restarts from zero. The resulting flags hold their value until the next tick. The mismatch count of the most recent frame is exported so that a transmit path can carry it as a far-end block error. A select input can swap it for a value supplied by a partner monitor.

Byte position arrives as row and column indices together with a start-of-frame strobe. A descrambled-valid flag qualifies each byte.

Top module: `line_bip_mon`

## Requirements
- R1: After a synchronous reset, both counters, all four threshold flags and the far-end output read zero.
- R2: Parity lane k (k = 0, 1, 2) is the XOR of every qualified byte whose column index modulo 3 equals k, excluding bytes with row < 3 and column < OH_COLS. The B2 bytes themselves are included. The B2 bytes are at row 4, columns 0, 1, 2, carrying lanes 0, 1, 2 in bits [7:0], [15:8], [23:16] of the check word.
- R3: The B2 bytes of frame N are checked against the parity of frame N-1. No check happens before a full frame has been seen since reset. A frame starts with a qualified byte that has the start strobe set.
- R4: Bytes presented with the descrambled-valid flag low have no effect, whatever their data, position or start strobe.
- R5: The mismatch count of a frame is the number of differing bits (0 to 24). With the select input low, the far-end output shows the count of the latest checked frame.
- R6: With the select input high, the far-end output equals the partner input one cycle later.
- R7: The bit-error counter adds each frame's mismatch count and saturates at all ones.
- R8: The block-error counter adds one for each frame whose mismatch count is nonzero and saturates at all ones.
- R9: On a tick, a counter restarts from zero. An increment landing in that same cycle is kept as the new value.
- R10: On a tick, each flag is set if the pre-tick count is greater than or equal to its threshold, and cleared otherwise. Flags change only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsc_ok_i | input | 1 | Byte is descrambled and valid |
| byte_i | input | 8 | Received byte |
| sof_i | input | 1 | First byte of a frame |
| row_i | input | ROW_W | Row index of the byte |
| col_i | input | COL_W | Column index of the byte |
| pm_tick_i | input | 1 | End of accumulation interval, read-and-clear |
| thr_bit_sf_i | input | CNT_W | Bit-error signal-fail threshold |
| thr_bit_sd_i | input | CNT_W | Bit-error signal-degrade threshold |
| thr_blk_sf_i | input | CNT_W | Block-error signal-fail threshold |
| thr_blk_sd_i | input | CNT_W | Block-error signal-degrade threshold |
| febe_sel_i | input | 1 | 1 selects the partner value for the far-end output |
| febe_ext_i | input | ERR_W | Partner error count |
| bit_cnt_o | output | CNT_W | Bit-error counter |
| blk_cnt_o | output | CNT_W | Block-error counter |
| bit_sf_o | output | 1 | Bit-error signal-fail flag |
| bit_sd_o | output | 1 | Bit-error signal-degrade flag |
| blk_sf_o | output | 1 | Block-error signal-fail flag |
| blk_sd_o | output | 1 | Block-error signal-degrade flag |
| febe_o | output | ERR_W | Far-end block error value |

## Verification
The hardest case to reach from the ports is a tick that lands in exactly the cycle in which a frame's mismatch count reaches the counters. This needs the stimulus to count the register stages behind the last B2 byte.

The bench sends that frame without gaps and raises the tick two bytes after the last B2 byte. It then expects the counters to hold only that frame's increment, and the flags to reflect the older totals.

Saturation and the full range of mismatch weights are reached with a narrow counter. The bench sweeps single-bit errors over all 24 positions and then masks of every weight from 0 to 24, while random unqualified bytes are interleaved.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  // Parity geometry shared by the monitor modules
  localparam int unsigned LANES    = 3;   // interleaved parity bytes
  localparam int unsigned SOH_ROWS = 3;   // rows holding section overhead
  localparam int unsigned B2_ROW   = 4;   // row carrying the parity bytes
  localparam int unsigned ERR_MAX  = 8 * LANES;

  typedef struct packed {
    logic sf;
    logic sd;
  } thr_flags_t;
endpackage

// File: rtl/bip24_acc.sv
module bip24_acc
  import lbm_pkg::*;
#(
  parameter int unsigned ROWS    = 9,
  parameter int unsigned COLS    = 270,
  parameter int unsigned OH_COLS = 9,
  parameter int unsigned ROW_W   = $clog2(ROWS),
  parameter int unsigned COL_W   = $clog2(COLS),
  parameter int unsigned ERR_W   = $clog2(ERR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dsc_ok_i,
  input  logic [7:0]       byte_i,
  input  logic             sof_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             err_vld_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int unsigned PW = 8 * LANES;

  logic [COL_W-1:0] lane;
  logic             in_soh;
  logic             in_b2;
  logic             last_b2;
  logic [PW-1:0]    acc;
  logic [PW-1:0]    ref_par;
  logic [PW-1:0]    rx_par;
  logic [PW-1:0]    diff;
  logic             seen_sof;
  logic             ref_vld;
  logic             chk_p;
  logic [ERR_W-1:0] pop;

  assign lane    = col_i % COL_W'(LANES);
  assign in_soh  = (row_i < ROW_W'(SOH_ROWS)) && (col_i < COL_W'(OH_COLS));
  assign in_b2   = (row_i == ROW_W'(B2_ROW)) && (col_i < COL_W'(LANES));
  assign last_b2 = (row_i == ROW_W'(B2_ROW)) && (col_i == COL_W'(LANES - 1));

  // One accumulator byte and one captured B2 byte per parity lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        acc[8*l +: 8]    <= '0;
        rx_par[8*l +: 8] <= '0;
      end else if (dsc_ok_i) begin
        if (sof_i) begin
          acc[8*l +: 8] <= '0;
        end else if (!in_soh && lane == COL_W'(l)) begin
          acc[8*l +: 8] <= acc[8*l +: 8] ^ byte_i;
        end
        if (in_b2 && col_i == COL_W'(l)) begin
          rx_par[8*l +: 8] <= byte_i;
        end
      end
    end
    assign diff[8*l +: 8] = ref_par[8*l +: 8] ^ rx_par[8*l +: 8];
  end

  always_comb begin
    pop = '0;
    for (int i = 0; i < PW; i++) begin
      pop = pop + ERR_W'(diff[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_par   <= '0;
      seen_sof  <= 1'b0;
      ref_vld   <= 1'b0;
      chk_p     <= 1'b0;
      err_vld_o <= 1'b0;
      err_cnt_o <= '0;
    end else begin
      chk_p     <= 1'b0;
      err_vld_o <= chk_p;
      if (chk_p) begin
        err_cnt_o <= pop;
      end
      if (dsc_ok_i) begin
        if (sof_i) begin
          seen_sof <= 1'b1;
          ref_vld  <= seen_sof;
          ref_par  <= acc;
        end
        if (last_b2 && ref_vld) begin
          chk_p <= 1'b1;
        end
      end
    end
  end

  // R5: a frame result never exceeds the number of parity bits
  a_r5_err_range: assert property (@(posedge clk) disable iff (rst)
    err_vld_o |-> (err_cnt_o <= ERR_W'(ERR_MAX)));

  // R3: a check is only started after a reference frame exists
  a_r3_ref_first: assert property (@(posedge clk) disable iff (rst)
    chk_p |-> seen_sof);
endmodule

// File: rtl/pm_counter.sv
module pm_counter
  import lbm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] thr_sf_i,
  input  logic [CNT_W-1:0] thr_sd_i,
  output logic [CNT_W-1:0] cnt_o,
  output thr_flags_t       flags_o
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;

  assign sum = {1'b0, cnt_o} + (CNT_W + 1)'(inc_i);
  assign nxt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      flags_o <= '0;
    end else if (clr_i) begin
      cnt_o      <= CNT_W'(inc_i);
      flags_o.sf <= (cnt_o >= thr_sf_i);
      flags_o.sd <= (cnt_o >= thr_sd_i);
    end else begin
      cnt_o <= nxt;
    end
  end

  // R7/R8: between ticks a counter never falls (saturation, no wrap)
  a_r7_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_o >= $past(cnt_o)));

  // R9: a tick with nothing to add leaves the counter at zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (clr_i && inc_i == '0) |=> (cnt_o == '0));

  // R10: flags only move on a tick
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> $stable(flags_o));
endmodule

// File: rtl/line_bip_mon.sv
module line_bip_mon
  import lbm_pkg::*;
#(
  parameter int unsigned ROWS    = 9,
  parameter int unsigned COLS    = 270,
  parameter int unsigned OH_COLS = 9,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ROW_W   = $clog2(ROWS),
  parameter int unsigned COL_W   = $clog2(COLS),
  parameter int unsigned ERR_W   = $clog2(ERR_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dsc_ok_i,
  input  logic [7:0]       byte_i,
  input  logic             sof_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             pm_tick_i,
  input  logic [CNT_W-1:0] thr_bit_sf_i,
  input  logic [CNT_W-1:0] thr_bit_sd_i,
  input  logic [CNT_W-1:0] thr_blk_sf_i,
  input  logic [CNT_W-1:0] thr_blk_sd_i,
  input  logic             febe_sel_i,
  input  logic [ERR_W-1:0] febe_ext_i,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic [CNT_W-1:0] blk_cnt_o,
  output logic             bit_sf_o,
  output logic             bit_sd_o,
  output logic             blk_sf_o,
  output logic             blk_sd_o,
  output logic [ERR_W-1:0] febe_o
);
  logic             err_vld;
  logic [ERR_W-1:0] err_cnt;
  logic [ERR_W-1:0] bit_inc;
  logic [0:0]       blk_inc;
  logic [ERR_W-1:0] febe_loc;
  thr_flags_t       bit_fl;
  thr_flags_t       blk_fl;

  bip24_acc #(
    .ROWS(ROWS), .COLS(COLS), .OH_COLS(OH_COLS),
    .ROW_W(ROW_W), .COL_W(COL_W), .ERR_W(ERR_W)
  ) acc_i (
    .clk(clk), .rst(rst), .dsc_ok_i(dsc_ok_i), .byte_i(byte_i),
    .sof_i(sof_i), .row_i(row_i), .col_i(col_i),
    .err_vld_o(err_vld), .err_cnt_o(err_cnt)
  );

  assign bit_inc = err_vld ? err_cnt : '0;
  assign blk_inc = err_vld && (err_cnt != '0);

  pm_counter #(.CNT_W(CNT_W), .INC_W(ERR_W)) bit_ctr_i (
    .clk(clk), .rst(rst), .inc_i(bit_inc), .clr_i(pm_tick_i),
    .thr_sf_i(thr_bit_sf_i), .thr_sd_i(thr_bit_sd_i),
    .cnt_o(bit_cnt_o), .flags_o(bit_fl)
  );

  pm_counter #(.CNT_W(CNT_W), .INC_W(1)) blk_ctr_i (
    .clk(clk), .rst(rst), .inc_i(blk_inc), .clr_i(pm_tick_i),
    .thr_sf_i(thr_blk_sf_i), .thr_sd_i(thr_blk_sd_i),
    .cnt_o(blk_cnt_o), .flags_o(blk_fl)
  );

  assign bit_sf_o = bit_fl.sf;
  assign bit_sd_o = bit_fl.sd;
  assign blk_sf_o = blk_fl.sf;
  assign blk_sd_o = blk_fl.sd;

  always_ff @(posedge clk) begin
    if (rst) begin
      febe_loc <= '0;
      febe_o   <= '0;
    end else begin
      if (err_vld) begin
        febe_loc <= err_cnt;
      end
      febe_o <= febe_sel_i ? febe_ext_i : febe_loc;
    end
  end

  // R8: block count steps by at most one per cycle outside a tick
  a_r8_blk_step: assert property (@(posedge clk) disable iff (rst)
    !pm_tick_i |=> ((blk_cnt_o == $past(blk_cnt_o)) ||
                    (blk_cnt_o == $past(blk_cnt_o) + 1'b1)));

  // R6: partner value reaches the far-end output one cycle later
  a_r6_ext_select: assert property (@(posedge clk) disable iff (rst)
    febe_sel_i |=> (febe_o == $past(febe_ext_i)));
endmodule

// File: tb/line_bip_mon_tb_top.sv
module line_bip_mon_tb_top;
  localparam int ROWS = 9;
  localparam int COLS = 12;
  localparam int OHC  = 3;
  localparam int CW   = 6;
  localparam int RW   = $clog2(ROWS);
  localparam int KW   = $clog2(COLS);
  localparam int EW   = 5;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dsc_ok = 1'b0;
  logic [7:0]    byte_d = '0;
  logic          sof = 1'b0;
  logic [RW-1:0] row = '0;
  logic [KW-1:0] col = '0;
  logic          tick = 1'b0;
  logic [CW-1:0] t_bsf = '0, t_bsd = '0, t_ksf = '0, t_ksd = '0;
  logic          fsel = 1'b0;
  logic [EW-1:0] fext = '0;
  logic [CW-1:0] bit_cnt, blk_cnt;
  logic          bit_sf, bit_sd, blk_sf, blk_sd;
  logic [EW-1:0] febe;

  int checks = 0;
  int errors = 0;
  int e_bit = 0, e_blk = 0, e_febe = 0;
  int e_bsf = 0, e_bsd = 0, e_ksf = 0, e_ksd = 0;
  bit have_ref = 0;
  logic [7:0] prev [3] = '{8'h0, 8'h0, 8'h0};

  always #4 clk = ~clk;

  line_bip_mon #(.ROWS(ROWS), .COLS(COLS), .OH_COLS(OHC), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .dsc_ok_i(dsc_ok), .byte_i(byte_d), .sof_i(sof),
    .row_i(row), .col_i(col), .pm_tick_i(tick),
    .thr_bit_sf_i(t_bsf), .thr_bit_sd_i(t_bsd),
    .thr_blk_sf_i(t_ksf), .thr_blk_sd_i(t_ksd),
    .febe_sel_i(fsel), .febe_ext_i(fext),
    .bit_cnt_o(bit_cnt), .blk_cnt_o(blk_cnt),
    .bit_sf_o(bit_sf), .bit_sd_o(bit_sd), .blk_sf_o(blk_sf), .blk_sd_o(blk_sd),
    .febe_o(febe)
  );

  function automatic int popc(input logic [23:0] v);
    int n = 0;
    for (int i = 0; i < 24; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R7 bit count"}, int'(bit_cnt), e_bit);
    chk({tag, " R8 block count"}, int'(blk_cnt), e_blk);
    chk({tag, " R10 bit sf"}, int'(bit_sf), e_bsf);
    chk({tag, " R10 bit sd"}, int'(bit_sd), e_bsd);
    chk({tag, " R10 blk sf"}, int'(blk_sf), e_ksf);
    chk({tag, " R10 blk sd"}, int'(blk_sd), e_ksd);
  endtask

  task automatic drive(input logic ok, input logic [7:0] d, input logic s,
                       input int r, input int c, input logic tk);
    @(negedge clk);
    dsc_ok = ok; byte_d = d; sof = s; row = RW'(r); col = KW'(c); tick = tk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h0, 1'b0, 0, 0, 1'b0);
  endtask

  task automatic do_tick();
    e_bsf = int'(e_bit >= int'(t_bsf));
    e_bsd = int'(e_bit >= int'(t_bsd));
    e_ksf = int'(e_blk >= int'(t_ksf));
    e_ksd = int'(e_blk >= int'(t_ksd));
    e_bit = 0;
    e_blk = 0;
    drive(1'b0, 8'h0, 1'b0, 0, 0, 1'b1);
    idle(3);
  endtask

  // One frame with B2 = previous parity XOR mask; tick_at >= 0 raises the
  // tick together with that byte index (gaps must be off then).
  task automatic send_frame(input logic [23:0] mask, input bit gaps, input int tick_at);
    logic [7:0] cur [3] = '{8'h0, 8'h0, 8'h0};
    logic [7:0] d;
    int idx = 0;
    int pc = popc(mask);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (gaps && ($urandom % 4 == 0))
          drive(1'b0, 8'($urandom), 1'($urandom), int'($urandom % ROWS),
                int'($urandom % COLS), 1'b0);
        d = 8'($urandom);
        if (r == 4 && c < 3) d = prev[c] ^ mask[8*c +: 8];
        if (!(r < 3 && c < OHC)) cur[c % 3] ^= d;
        drive(1'b1, d, (r == 0 && c == 0), r, c, (idx == tick_at));
        idx++;
      end
    end
    idle(4);
    for (int k = 0; k < 3; k++) prev[k] = cur[k];
    if (have_ref) begin
      e_febe = pc;
      if (tick_at >= 0) begin
        e_bsf = int'(e_bit >= int'(t_bsf));
        e_bsd = int'(e_bit >= int'(t_bsd));
        e_ksf = int'(e_blk >= int'(t_ksf));
        e_ksd = int'(e_blk >= int'(t_ksd));
        e_bit = pc;
        e_blk = int'(pc != 0);
      end else begin
        e_bit = sat(e_bit + pc);
        e_blk = sat(e_blk + int'(pc != 0));
      end
    end
    have_ref = 1;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    check_all("R1 reset");
    chk("R1 febe", int'(febe), 0);

    // R3: first frame has no reference, mask must not count
    send_frame(24'hFFFFFF, 1'b0, -1);
    check_all("R3 first frame");
    chk("R5 febe first", int'(febe), 0);

    // R2/R5: single-bit error at each of the 24 lane bit positions
    for (int b = 0; b < 24; b++) begin
      send_frame(24'(1) << b, 1'b0, -1);
      check_all("R2 single bit");
      chk("R5 febe single", int'(febe), e_febe);
    end

    // R10: thresholds on both sides of the counts (bit 24, block 24)
    t_bsf = 6'd20; t_bsd = 6'd30; t_ksf = 6'd25; t_ksd = 6'd24;
    do_tick();
    check_all("R9 tick");

    // R4/R7/R8: every mask weight, with unqualified garbage interleaved
    for (int k = 0; k <= 24; k++) begin
      send_frame(24'((64'(1) << k) - 1), 1'b1, -1);
      check_all("R4 weight sweep");
      chk("R5 febe weight", int'(febe), k);
    end

    // R10: flag exactly at threshold, flags hold across frames
    t_bsf = 6'd63; t_bsd = 6'd62; t_ksf = 6'd25; t_ksd = 6'd24;
    do_tick();
    check_all("R10 at threshold");
    send_frame(24'h000100, 1'b0, -1);
    check_all("R10 hold");

    // R9: tick in the very cycle the increment reaches the counters
    // (last B2 byte index 4*COLS+2, two more register stages)
    send_frame(24'h000707, 1'b0, 4 * COLS + 2 + 2);
    check_all("R9 tick collision");

    // R8: block counter saturation
    for (int f = 0; f < 66; f++) send_frame(24'h800000, 1'b0, -1);
    check_all("R8 saturation");

    // R6: partner value selection
    fsel = 1'b1;
    for (int v = 0; v < 32; v++) begin
      @(negedge clk); fext = EW'(v);
      @(negedge clk);
      chk("R6 partner", int'(febe), v);
    end
    fsel = 1'b0;
    idle(2);
    chk("R5 local after deselect", int'(febe), e_febe);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule